// File: doc/BRIEF.md
# Quad-Channel Thermal Protection Sequencer

This block is the digital control core of a four-channel high-side power switch. Each channel has a logic-level command input, an enable that drives its power stage, and an active-low status flag. The analog side supplies comparator flags. Per channel these are a junction over-temperature flag, a junction-cooled flag and a current-limit flag. Shared by all channels are a case over-temperature flag, a case-cooled flag and an undervoltage flag. All of them are brought into the clock domain through two-flop synchronizers.

A channel that overheats while commanded on is switched off, and its status goes low. It stays off until its junction-cooled flag reports that the lower reset threshold has been crossed, which gives hysteresis between shutdown and restart. If the case also overheats while a channel is overloaded, that channel stays locked off until the case-cooled flag is seen. Channels that become eligible to restart are not released together. A round-robin restart arbiter grants them one at a time, spaced by `RESTART_GAP` clock cycles, so the supply never sees several loads switch on in the same instant. Channels that are not overloaded keep following their commands throughout.

Top module: `quad_thermal_seq`

## Requirements
- R1: Out of reset every enable is 0 and every status is 1. In normal operation each enable follows its command and its status stays 1. A command change reaches the enable on the third rising clock edge after it is applied.
- R2: A channel whose command is 1 while its junction over-temperature flag is 1 turns its enable to 0 and its status to 0.
- R3: A channel stopped by junction over-temperature stays off, with status 0, until its junction-cooled flag is 1. Clearing only the over-temperature flag does not restart it.
- R4: While a channel is stopped for junction temperature, a case over-temperature flag of 1 locks it off. While locked, a junction-cooled flag of 1 does not restart it. It becomes eligible to restart only once both the case-cooled flag and its junction-cooled flag are 1.
- R5: At most one channel restarts on any clock edge. The arbiter passes restart priority round-robin. After reset, channel 0 has first priority. After a channel (index k) is granted, the search starts at index k+1 and wraps from 3 to 0.
- R6: When several channels are waiting, consecutive restarts are exactly `RESTART_GAP` cycles apart. After a restart, no other restart happens in fewer than `RESTART_GAP` cycles.
- R7: A channel that is not overloaded keeps following its command while other channels are shut down.
- R8: An undervoltage flag of 1 forces every enable to 0 and leaves the status of running channels at 1. Once the flag clears, the enables follow their commands again.
- R9: A channel in current limit, with no thermal flag set, stays enabled and keeps status 1. If the case over-temperature flag is 1 while the channel is commanded on and in current limit, the channel is locked off with status 0, as in R4.
- R10: If a stopped channel's command goes to 0 while the cooled flag it is waiting for is 1, its lockout clears and its status returns to 1. A later command of 1 enables it within three edges, without waiting for a restart grant.
- R11: A case over-temperature flag has no effect on a running channel that is neither in junction shutdown nor in current limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | N | Per-channel on command |
| jt_hot_i | input | N | Per-channel junction over-temperature flag |
| jt_cool_i | input | N | Per-channel junction below reset threshold flag |
| case_hot_i | input | 1 | Shared case over-temperature flag |
| case_cool_i | input | 1 | Shared case below reset threshold flag |
| uv_i | input | 1 | Supply undervoltage flag |
| ilim_i | input | N | Per-channel current-limit active flag |
| drv_en_o | output | N | Per-channel power stage enable |
| stat_n_o | output | N | Per-channel status, 0 = thermal fault pending |

## Verification
A change of command, junction flag or undervoltage flag reaches the enable and status registers on the third rising edge after it is applied. The bench therefore drives on a falling edge and samples three falling edges later. It also checks at the second falling edge that nothing has moved early. A restart takes one edge longer than a direct path, because the channel first enters its waiting state and is then granted. Restart order and spacing are measured by stamping, with a cycle count, the falling edge at which each enable rises, and comparing the differences with `RESTART_GAP` and the round-robin order the bench predicts. Lockouts are checked by holding the cooled flags in their blocking state for many cycles and confirming the enable stays 0.

// File: rtl/qts_pkg.sv
package qts_pkg;

    typedef enum logic [1:0] {
        CH_RUN   = 2'd0,  // following command
        CH_JTRIP = 2'd1,  // junction shutdown, waiting to cool
        CH_CLOCK = 2'd2,  // case lockout
        CH_WAIT  = 2'd3   // cooled, waiting for restart grant
    } ch_state_e;

    typedef struct packed {
        ch_state_e st;
        logic      drv;
        logic      stat_n;
    } ch_reg_t;

endpackage

// File: rtl/qts_sync.sv
module qts_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qts_channel.sv
module qts_channel
    import qts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic jt_hot,
    input  logic jt_cool,
    input  logic case_hot,
    input  logic case_cool,
    input  logic uv,
    input  logic ilim,
    input  logic grant,
    output logic req,
    output logic drv_en,
    output logic stat_n
);
    ch_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            CH_RUN: begin
                if (cmd && jt_hot) begin
                    r_d.st = CH_JTRIP;
                end else if (cmd && ilim && case_hot) begin
                    r_d.st = CH_CLOCK;
                end
            end
            CH_JTRIP: begin
                if (case_hot) begin
                    r_d.st = CH_CLOCK;
                end else if (jt_cool) begin
                    r_d.st = cmd ? CH_WAIT : CH_RUN;
                end
            end
            CH_CLOCK: begin
                if (case_cool) begin
                    if (!jt_cool) begin
                        r_d.st = CH_JTRIP;
                    end else begin
                        r_d.st = cmd ? CH_WAIT : CH_RUN;
                    end
                end
            end
            CH_WAIT: begin
                if (!cmd) begin
                    r_d.st = CH_RUN;
                end else if (jt_hot) begin
                    r_d.st = CH_JTRIP;
                end else if (grant) begin
                    r_d.st = CH_RUN;
                end
            end
            default: r_d.st = CH_RUN;
        endcase
        r_d.drv    = (r_d.st == CH_RUN) && cmd && !uv;
        r_d.stat_n = (r_d.st == CH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: CH_RUN, drv: 1'b0, stat_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign req    = (r_q.st == CH_WAIT) && cmd;
    assign drv_en = r_q.drv;
    assign stat_n = r_q.stat_n;
endmodule

// File: rtl/qts_restart_arb.sv
module qts_restart_arb #(
    parameter int N   = 4,
    parameter int GAP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = (GAP > 1) ? $clog2(GAP + 1) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } arb_reg_t;

    arb_reg_t r_d, r_q;

    always_comb begin
        logic [PW-1:0] idx;
        logic          found;
        r_d   = r_q;
        gnt   = '0;
        found = 1'b0;
        idx   = '0;
        if (r_q.cnt == '0) begin
            for (int k = 0; k < N; k++) begin
                idx = PW'((int'(r_q.ptr) + k) % N);
                if (!found && req[idx]) begin
                    found    = 1'b1;
                    gnt[idx] = 1'b1;
                    r_d.ptr  = PW'((int'(idx) + 1) % N);
                end
            end
        end
        if (found) begin
            r_d.cnt = CW'(GAP - 1);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/quad_thermal_seq.sv
module quad_thermal_seq #(
    parameter int N           = 4,
    parameter int RESTART_GAP = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cmd_i,
    input  logic [N-1:0] jt_hot_i,
    input  logic [N-1:0] jt_cool_i,
    input  logic         case_hot_i,
    input  logic         case_cool_i,
    input  logic         uv_i,
    input  logic [N-1:0] ilim_i,
    output logic [N-1:0] drv_en_o,
    output logic [N-1:0] stat_n_o
);
    localparam int SW = 3 + 4 * N;

    logic [SW-1:0] raw_flags, s_flags;
    logic          case_hot_s, case_cool_s, uv_s;
    logic [N-1:0]  cmd_s, jt_hot_s, jt_cool_s, ilim_s;
    logic [N-1:0]  req, gnt;

    assign raw_flags = {ilim_i, jt_cool_i, jt_hot_i, cmd_i, uv_i, case_cool_i, case_hot_i};

    qts_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_flags),
        .dout (s_flags)
    );

    assign case_hot_s  = s_flags[0];
    assign case_cool_s = s_flags[1];
    assign uv_s        = s_flags[2];
    assign cmd_s       = s_flags[3 +: N];
    assign jt_hot_s    = s_flags[3 + N +: N];
    assign jt_cool_s   = s_flags[3 + 2*N +: N];
    assign ilim_s      = s_flags[3 + 3*N +: N];

    for (genvar i = 0; i < N; i++) begin : g_ch
        qts_channel ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_s[i]),
            .jt_hot   (jt_hot_s[i]),
            .jt_cool  (jt_cool_s[i]),
            .case_hot (case_hot_s),
            .case_cool(case_cool_s),
            .uv       (uv_s),
            .ilim     (ilim_s[i]),
            .grant    (gnt[i]),
            .req      (req[i]),
            .drv_en   (drv_en_o[i]),
            .stat_n   (stat_n_o[i])
        );
    end

    qts_restart_arb #(.N(N), .GAP(RESTART_GAP)) arb_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .gnt  (gnt)
    );
endmodule

// File: rtl/qts_checker.sv
module qts_checker #(
    parameter int N   = 4,
    parameter int GAP = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] drv_en_o,
    input logic [N-1:0] stat_n_o,
    input logic         uv_s,
    input logic [N-1:0] gnt
);
    localparam int SW = $clog2(GAP + 1) + 1;
    localparam logic [SW-1:0] SMAX = SW'(GAP);

    logic [SW-1:0] since_q;
    logic [N-1:0]  prev_stat_q;
    logic [N-1:0]  restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q     <= SMAX;
            prev_stat_q <= '1;
        end else begin
            prev_stat_q <= stat_n_o;
            if (gnt != '0) begin
                since_q <= '0;
            end else if (since_q != SMAX) begin
                since_q <= since_q + SW'(1);
            end
        end
    end

    assign restart = drv_en_o & ~prev_stat_q;

    // R8: undervoltage seen by the channels forces every enable low
    a_r8_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (drv_en_o == '0));

    // R5: restart grants are at most one-hot
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R5: no two channels leave a fault state into an enabled output together
    a_r5_one_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(restart) <= 1);

    // R6: grants keep the configured spacing
    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (since_q >= SW'(GAP - 1)));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2: a pending fault never coexists with an enabled stage
        a_r2_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
            !stat_n_o[i] |-> !drv_en_o[i]);
    end
endmodule

bind quad_thermal_seq qts_checker #(.N(N), .GAP(RESTART_GAP)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_en_o(drv_en_o),
    .stat_n_o(stat_n_o),
    .uv_s    (uv_s),
    .gnt     (gnt)
);

// File: tb/quad_thermal_seq_tb_top.sv
`timescale 1ns/1ps
module quad_thermal_seq_tb_top;
    localparam int N   = 4;
    localparam int GAP = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] cmd = '0, jt_hot = '0, jt_cool = '0, ilim = '0;
    logic         case_hot = 1'b0, case_cool = 1'b0, uv = 1'b0;
    logic [N-1:0] drv, stat;

    int checks = 0;
    int fails  = 0;
    int ptr    = 0;   // predicted round-robin pointer (R5)
    bit done   = 1'b0;

    always #10 clk = ~clk;

    quad_thermal_seq #(.N(N), .RESTART_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .jt_hot_i(jt_hot),
        .jt_cool_i(jt_cool), .case_hot_i(case_hot), .case_cool_i(case_cool),
        .uv_i(uv), .ilim_i(ilim), .drv_en_o(drv), .stat_n_o(stat)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // waits for an enable to rise, returns cycles waited or -1
    task automatic wait_on(input int ch, input int limit, output int cyc);
        cyc = -1;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            if (drv[ch]) begin
                cyc = c;
                break;
            end
        end
    endtask

    // records the rise cycle of each channel in mask, checks order and spacing
    task automatic stagger(input logic [N-1:0] mask, input string tag);
        int t [N];
        int exp_order [N];
        int cnt;
        int p;
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) t[i] = -1;
        m = mask; p = ptr; cnt = 0;
        for (int r = 0; r < N; r++) begin
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = (p + k) % N;
                if (m[idx]) begin
                    exp_order[cnt] = idx;
                    cnt++;
                    m[idx] = 1'b0;
                    p = (idx + 1) % N;
                    break;
                end
            end
        end
        jt_hot  = jt_hot & ~mask;
        jt_cool = jt_cool | mask;
        for (int c = 1; c <= 4 * GAP + 20; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (drv[i] && t[i] < 0) t[i] = c;
        end
        for (int j = 1; j < cnt; j++) begin
            chk({tag, " R5 order"}, int'(t[exp_order[j]] > t[exp_order[j-1]]), 1);
            chk({tag, " R6 gap"}, t[exp_order[j]] - t[exp_order[j-1]], GAP);
        end
        for (int j = 0; j < cnt; j++) chk({tag, " R5 restarted"}, int'(t[exp_order[j]] > 0), 1);
        ptr = p;
        jt_cool = '0;
    endtask

    task automatic t_reset();
        chk("R1 reset drv", drv, 0);
        chk("R1 reset stat", stat, 4'hF);
    endtask

    task automatic t_follow();
        cmd = 4'b1010;
        tick(2);
        chk("R1 latency not early", drv, 0);
        tick(1);
        chk("R1 follow drv", drv, 4'b1010);
        chk("R1 follow stat", stat, 4'hF);
        cmd = 4'b0101; tick(3);
        chk("R1 follow drv 2", drv, 4'b0101);
        cmd = 4'b1111; tick(3);
        chk("R1 all on", drv, 4'hF);
    endtask

    task automatic t_trip();
        int cyc;
        jt_hot[0] = 1'b1; tick(3);
        chk("R2 trip drv", drv, 4'b1110);
        chk("R2 trip stat", stat, 4'b1110);
        cmd[1] = 1'b0; tick(3);
        chk("R7 neighbour follows off", drv, 4'b1100);
        cmd[1] = 1'b1; tick(3);
        chk("R7 neighbour follows on", drv, 4'b1110);
        jt_hot[0] = 1'b0; tick(20);
        chk("R3 no restart before cooled", drv[0], 0);
        chk("R3 stat still low", stat[0], 0);
        jt_cool[0] = 1'b1;
        wait_on(0, 20, cyc);
        chk("R3 restart after cooled", int'(cyc > 0), 1);
        chk("R3 stat back high", stat[0], 1);
        ptr = 1;
        jt_cool[0] = 1'b0; tick(2);
    endtask

    task automatic t_case();
        int cyc;
        jt_hot[3] = 1'b1; tick(3);
        chk("R2 ch3 trip", drv[3], 0);
        case_hot = 1'b1; tick(3);
        jt_hot[3] = 1'b0; jt_cool[3] = 1'b1; tick(30);
        chk("R4 held by case", drv[3], 0);
        chk("R4 stat low", stat[3], 0);
        chk("R11 running unaffected", drv[2:0], 3'b111);
        case_hot = 1'b0; case_cool = 1'b1;
        wait_on(3, 20, cyc);
        chk("R4 release on case cool", int'(cyc > 0), 1);
        ptr = 0;
        case_cool = 1'b0; jt_cool[3] = 1'b0; tick(2);
    endtask

    task automatic t_stagger();
        jt_hot = 4'b0111; tick(3);
        chk("R2 multi trip", drv, 4'b1000);
        stagger(4'b0111, "S1");
        jt_hot = 4'b1010; tick(3);
        chk("R2 multi trip 2", drv, 4'b0101);
        stagger(4'b1010, "S2");
        chk("R6 all back", drv, 4'hF);
    endtask

    task automatic t_clear();
        jt_hot[2] = 1'b1; tick(3);
        chk("R2 ch2 trip", stat[2], 0);
        cmd[2] = 1'b0; jt_hot[2] = 1'b0; jt_cool[2] = 1'b1; tick(3);
        chk("R10 stat cleared", stat[2], 1);
        chk("R10 drv off", drv[2], 0);
        cmd[2] = 1'b1; tick(3);
        chk("R10 direct re-enable", drv[2], 1);
        jt_cool[2] = 1'b0; tick(2);
    endtask

    task automatic t_ilim();
        int cyc;
        ilim[1] = 1'b1; tick(10);
        chk("R9 limit stays on", drv[1], 1);
        chk("R9 limit stat high", stat[1], 1);
        case_hot = 1'b1; tick(3);
        chk("R9 limit with case hot off", drv[1], 0);
        chk("R9 stat low", stat[1], 0);
        chk("R11 others on", {drv[3:2], drv[0]}, 3'b111);
        case_hot = 1'b0; case_cool = 1'b1; jt_cool = 4'hF;
        wait_on(1, 20, cyc);
        chk("R9 release", int'(cyc > 0), 1);
        ilim = '0; case_cool = 1'b0; jt_cool = '0; tick(3);
    endtask

    task automatic t_uv();
        uv = 1'b1; tick(3);
        chk("R8 uv off", drv, 0);
        chk("R8 uv stat", stat, 4'hF);
        uv = 1'b0; tick(3);
        chk("R8 uv release", drv, 4'hF);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_follow();
        t_trip();
        t_case();
        t_stagger();
        t_clear();
        t_ilim();
        t_uv();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule